// File: doc/BRIEF.md
# Floating-Point NaN Propagation Unit

This unit sits at the result stage of a two-operand floating-point operation. It receives the destination operand and the source operand in single, double or 80-bit extended format. It finds out whether either operand is a quiet or a signaling NaN and decides which NaN value, if any, becomes the result. A NaN taken from an operand keeps its sign and payload. Its quiet bit is always forced to one, so a signaling NaN leaves the unit as a quiet NaN.

When an operand is a signaling NaN, the unit raises a status flag. If that exception is enabled, the unit also requests a trap and blocks the write to the destination. When the surrounding datapath reports an invalid operation and neither operand is a NaN, the unit supplies the format's default NaN. The default NaN is positive, has an all-ones exponent and has every fraction bit set. All outputs are registered one clock after an input beat that is marked valid.

Top module: `fpnan_prop`

## Requirements
- R1: Format code 0 selects single precision in bits [31:0] (sign 31, exponent [30:23], fraction [22:0]). Code 1 selects double precision in bits [63:0] (sign 63, exponent [62:52], fraction [51:0]). Codes 2 and 3 select 80-bit extended (sign 79, exponent [78:64], integer bit 63, fraction [62:0]). An operand is a NaN when its exponent is all ones and its fraction is nonzero. The top fraction bit (bit 22, 51 or 62) is one for a quiet NaN and zero for a signaling NaN.
- R2: When the destination operand is any NaN, quiet or signaling, the result is the destination operand, whatever the source operand holds.
- R3: When the source operand is a NaN and the destination operand is not, the result is the source operand.
- R4: A propagated NaN keeps its sign and payload, and its quiet bit is set to one. Result bits above the format width are zero.
- R5: `snan_flag` is 1 whenever either operand is a signaling NaN, and 0 otherwise.
- R6: When a signaling NaN is present and `snan_trap_en` is 1, `trap_req` is 1 and `wr_en` is 0.
- R7: When a signaling NaN is present and `snan_trap_en` is 0, `trap_req` is 0, `wr_en` is 1, and the result is the quieted NaN chosen by R2 or R3.
- R8: When `invalid_op` is 1 and neither operand is a NaN, the result is the default NaN and `wr_en` is 1. The default NaN is 0x7FFFFFFF for single, 0x7FFFFFFFFFFFFFFF for double, and sign/exponent 0x7FFF with a 64-bit significand of all ones for extended.
- R9: When neither operand is a NaN and `invalid_op` is 0, `nan_hit`, `wr_en`, `snan_flag` and `trap_req` are 0, and the result is zero.
- R10: All outputs appear one clock after the input beat. When `out_valid` is 0, including during reset, every other output is 0.
- R11: An operand NaN takes precedence over the default NaN when `invalid_op` is also 1.
- R12: The extended integer bit (bit 63) plays no part in the NaN test. An all-ones exponent with a zero fraction is an infinity even when bit 63 is one. A NaN with bit 63 cleared is still a NaN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand beat is valid |
| fmt | input | 2 | Format code (R1) |
| dst_op | input | 80 | Destination operand, right-aligned |
| src_op | input | 80 | Source operand, right-aligned |
| invalid_op | input | 1 | The operation created a new NaN |
| snan_trap_en | input | 1 | Signaling-NaN exception enabled |
| out_valid | output | 1 | Registered outputs are valid |
| result | output | 80 | Chosen NaN or default NaN |
| wr_en | output | 1 | Write the result to the destination |
| snan_flag | output | 1 | Signaling-NaN status bit |
| trap_req | output | 1 | Trap request for an enabled signaling NaN |
| nan_hit | output | 1 | The unit supplies the result |

## Verification
Quieting a signaling NaN for propagation and raising the exception can happen in the same cycle. With the trap enabled, the trap also vetoes the write that the propagation would otherwise cause. The bench provokes this overlap by placing signaling NaNs on one operand or on both, alongside quiet NaNs and plain numbers on the other, with the enable both set and clear. It does this in every format and with `invalid_op` both low and high. For each case the bench judges the result value, the flag, the trap and the write enable together against a model built from the selection and exception rules.

// File: rtl/fpnan_pkg.sv
package fpnan_pkg;

    localparam int OP_W  = 80;
    localparam int SGL_E = 8;
    localparam int SGL_F = 23;
    localparam int DBL_E = 11;
    localparam int DBL_F = 52;
    localparam int EXT_E = 15;
    localparam int EXT_F = 63;
    localparam int SGL_W = 1 + SGL_E + SGL_F;
    localparam int DBL_W = 1 + DBL_E + DBL_F;

    typedef enum logic [1:0] {
        FMT_SGL  = 2'd0,
        FMT_DBL  = 2'd1,
        FMT_EXT  = 2'd2,
        FMT_EXT2 = 2'd3
    } fmt_e;

    typedef struct packed {
        logic            vld;
        logic [OP_W-1:0] res;
        logic            we;
        logic            flag;
        logic            trap;
        logic            hit;
    } stage_t;

    function automatic logic [OP_W-1:0] dflt_nan(input logic [1:0] f);
        logic [OP_W-1:0] v;
        v = '0;
        case (f)
            FMT_SGL: v[SGL_W-2:0] = '1;
            FMT_DBL: v[DBL_W-2:0] = '1;
            default: v[OP_W-2:0]  = '1;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/fpnan_classify.sv
module fpnan_classify
    import fpnan_pkg::*;
(
    input  logic [1:0]      fmt,
    input  logic [OP_W-1:0] op,
    output logic            is_q,
    output logic            is_s,
    output logic [OP_W-1:0] quieted
);
    logic exp_ones;
    logic frac_nz;
    logic qbit;

    always_comb begin
        quieted = '0;
        case (fmt)
            FMT_SGL: begin
                exp_ones = &op[SGL_F +: SGL_E];
                frac_nz  = |op[SGL_F-1:0];
                qbit     = op[SGL_F-1];
                quieted[SGL_W-1:0] = op[SGL_W-1:0];
                quieted[SGL_F-1]   = 1'b1;
            end
            FMT_DBL: begin
                exp_ones = &op[DBL_F +: DBL_E];
                frac_nz  = |op[DBL_F-1:0];
                qbit     = op[DBL_F-1];
                quieted[DBL_W-1:0] = op[DBL_W-1:0];
                quieted[DBL_F-1]   = 1'b1;
            end
            default: begin
                // integer bit (EXT_F) sits between exponent and fraction
                exp_ones = &op[EXT_F+1 +: EXT_E];
                frac_nz  = |op[EXT_F-1:0];
                qbit     = op[EXT_F-1];
                quieted  = op;
                quieted[EXT_F-1] = 1'b1;
            end
        endcase
        is_q = exp_ones && frac_nz && qbit;
        is_s = exp_ones && frac_nz && !qbit;
    end

endmodule

// File: rtl/fpnan_select.sv
module fpnan_select
    import fpnan_pkg::*;
(
    input  logic            in_valid,
    input  logic [1:0]      fmt,
    input  logic            invalid_op,
    input  logic            snan_trap_en,
    input  logic [1:0]      is_q,
    input  logic [1:0]      is_s,
    input  logic [OP_W-1:0] quieted [2],
    output stage_t          stage_d
);
    logic dst_nan;
    logic src_nan;
    logic any_snan;

    always_comb begin
        dst_nan  = is_q[0] | is_s[0];
        src_nan  = is_q[1] | is_s[1];
        any_snan = |is_s;
        stage_d  = '0;
        if (in_valid) begin
            stage_d.vld  = 1'b1;
            stage_d.flag = any_snan;
            stage_d.trap = any_snan && snan_trap_en;
            stage_d.hit  = dst_nan || src_nan || invalid_op;
            if (dst_nan)
                stage_d.res = quieted[0];
            else if (src_nan)
                stage_d.res = quieted[1];
            else if (invalid_op)
                stage_d.res = dflt_nan(fmt);
            stage_d.we = stage_d.hit && !stage_d.trap;
        end
    end

endmodule

// File: rtl/fpnan_prop.sv
module fpnan_prop
    import fpnan_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [1:0]      fmt,
    input  logic [OP_W-1:0] dst_op,
    input  logic [OP_W-1:0] src_op,
    input  logic            invalid_op,
    input  logic            snan_trap_en,
    output logic            out_valid,
    output logic [OP_W-1:0] result,
    output logic            wr_en,
    output logic            snan_flag,
    output logic            trap_req,
    output logic            nan_hit
);
    localparam int N_OPS = 2;

    logic [OP_W-1:0] ops     [N_OPS];
    logic [OP_W-1:0] quieted [N_OPS];
    logic [N_OPS-1:0] is_q;
    logic [N_OPS-1:0] is_s;
    stage_t stage_d;
    stage_t stage_q;

    assign ops[0] = dst_op;
    assign ops[1] = src_op;

    for (genvar i = 0; i < N_OPS; i++) begin : g_cls
        fpnan_classify u_cls (
            .fmt     (fmt),
            .op      (ops[i]),
            .is_q    (is_q[i]),
            .is_s    (is_s[i]),
            .quieted (quieted[i])
        );
    end

    fpnan_select u_sel (
        .in_valid     (in_valid),
        .fmt          (fmt),
        .invalid_op   (invalid_op),
        .snan_trap_en (snan_trap_en),
        .is_q         (is_q),
        .is_s         (is_s),
        .quieted      (quieted),
        .stage_d      (stage_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign out_valid = stage_q.vld;
    assign result    = stage_q.res;
    assign wr_en     = stage_q.we;
    assign snan_flag = stage_q.flag;
    assign trap_req  = stage_q.trap;
    assign nan_hit   = stage_q.hit;

    // R6
    trap_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> !wr_en);

    // R5
    trap_has_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> snan_flag);

    // R10
    idle_outputs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(wr_en || snan_flag || trap_req || nan_hit || (|result)));

    // R2
    dst_nan_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (is_q[0] || is_s[0])) |=> (nan_hit && result == $past(quieted[0])));

    // R3
    src_nan_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_q[0] && !is_s[0] && (is_q[1] || is_s[1]))
        |=> (result == $past(quieted[1])));

    // R1
    class_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(is_q[0] && is_s[0]) && !(is_q[1] && is_s[1]));

endmodule

// File: tb/sim_fpnan_prop.sv
module sim_fpnan_prop;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  fmt = 2'd0;
    logic [79:0] dst_op = '0;
    logic [79:0] src_op = '0;
    logic        invalid_op = 1'b0;
    logic        snan_trap_en = 1'b0;
    logic        out_valid;
    logic [79:0] result;
    logic        wr_en;
    logic        snan_flag;
    logic        trap_req;
    logic        nan_hit;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    fpnan_prop u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt(fmt),
        .dst_op(dst_op), .src_op(src_op), .invalid_op(invalid_op),
        .snan_trap_en(snan_trap_en), .out_valid(out_valid), .result(result),
        .wr_en(wr_en), .snan_flag(snan_flag), .trap_req(trap_req), .nan_hit(nan_hit)
    );

    // kinds: 0 number, 1 quiet NaN, 2 signaling NaN, 3 infinity
    // choice: 0 none, 1 destination, 2 source, 3 default NaN
    typedef struct packed {
        logic [1:0] f;
        logic [1:0] dk;
        logic [1:0] sk;
        logic       inv;
        logic       en;
        logic [1:0] ch;
        logic       flg;
        logic       trp;
        logic       we;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t TBL [NV] = '{
        '{2'd0, 2'd1, 2'd0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1},
        '{2'd0, 2'd0, 2'd1, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 1'b1},
        '{2'd0, 2'd1, 2'd1, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1},
        '{2'd0, 2'd0, 2'd2, 1'b0, 1'b0, 2'd2, 1'b1, 1'b0, 1'b1},
        '{2'd0, 2'd0, 2'd2, 1'b0, 1'b1, 2'd2, 1'b1, 1'b1, 1'b0},
        '{2'd0, 2'd2, 2'd1, 1'b0, 1'b0, 2'd1, 1'b1, 1'b0, 1'b1},
        '{2'd0, 2'd1, 2'd2, 1'b0, 1'b1, 2'd1, 1'b1, 1'b1, 1'b0},
        '{2'd0, 2'd0, 2'd0, 1'b1, 1'b0, 2'd3, 1'b0, 1'b0, 1'b1},
        '{2'd0, 2'd3, 2'd3, 1'b1, 1'b1, 2'd3, 1'b0, 1'b0, 1'b1},
        '{2'd0, 2'd3, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0},
        '{2'd1, 2'd1, 2'd1, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1},
        '{2'd1, 2'd0, 2'd2, 1'b1, 1'b0, 2'd2, 1'b1, 1'b0, 1'b1},
        '{2'd1, 2'd0, 2'd0, 1'b1, 1'b1, 2'd3, 1'b0, 1'b0, 1'b1},
        '{2'd2, 2'd2, 2'd2, 1'b0, 1'b1, 2'd1, 1'b1, 1'b1, 1'b0},
        '{2'd2, 2'd3, 2'd1, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 1'b1},
        '{2'd2, 2'd0, 2'd0, 1'b1, 1'b0, 2'd3, 1'b0, 1'b0, 1'b1},
        '{2'd3, 2'd0, 2'd1, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 1'b1},
        '{2'd2, 2'd2, 2'd0, 1'b0, 1'b0, 2'd1, 1'b1, 1'b0, 1'b1}
    };

    localparam logic [63:0] SALT_D = 64'hA5C3_1E7B_9D24_6F81;
    localparam logic [63:0] SALT_S = 64'h5B2E_C4D6_03F9_7A1C;

    function automatic logic [79:0] mk_op(input logic [1:0] f, input logic [1:0] k,
                                          input logic sg, input logic [63:0] s);
        case (f)
            2'd0: case (k)
                2'd0: return {48'h0, sg, 8'h40, s[22:0]};
                2'd1: return {48'h0, sg, 8'hFF, 1'b1, s[21:0]};
                2'd2: return {48'h0, sg, 8'hFF, 1'b0, s[21:1], 1'b1};
                default: return {48'h0, sg, 8'hFF, 23'h0};
            endcase
            2'd1: case (k)
                2'd0: return {16'h0, sg, 11'h400, s[51:0]};
                2'd1: return {16'h0, sg, 11'h7FF, 1'b1, s[50:0]};
                2'd2: return {16'h0, sg, 11'h7FF, 1'b0, s[50:1], 1'b1};
                default: return {16'h0, sg, 11'h7FF, 52'h0};
            endcase
            default: case (k)
                2'd0: return {sg, 15'h3FFF, 1'b1, s[62:0]};
                2'd1: return {sg, 15'h7FFF, 1'b1, 1'b1, s[61:0]};
                2'd2: return {sg, 15'h7FFF, 1'b1, 1'b0, s[61:1], 1'b1};
                default: return {sg, 15'h7FFF, 1'b1, 63'h0};
            endcase
        endcase
    endfunction

    function automatic logic [79:0] quiet(input logic [1:0] f, input logic [79:0] v);
        logic [79:0] r;
        r = v;
        case (f)
            2'd0: r[22] = 1'b1;
            2'd1: r[51] = 1'b1;
            default: r[62] = 1'b1;
        endcase
        return r;
    endfunction

    function automatic logic [79:0] dflt(input logic [1:0] f);
        case (f)
            2'd0: return 80'h0000_0000_0000_7FFF_FFFF;
            2'd1: return {16'h0, 64'h7FFF_FFFF_FFFF_FFFF};
            default: return {16'h7FFF, 64'hFFFF_FFFF_FFFF_FFFF};
        endcase
    endfunction

    task automatic drive(input logic [1:0] f, input logic [79:0] d, input logic [79:0] s,
                         input logic inv, input logic en);
        in_valid = 1'b1; fmt = f; dst_op = d; src_op = s;
        invalid_op = inv; snan_trap_en = en;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check(input string req, input logic [79:0] er, input logic ev,
                         input logic ewe, input logic efl, input logic etr, input logic eh);
        checks++;
        if (out_valid !== ev || result !== er || wr_en !== ewe || snan_flag !== efl ||
            trap_req !== etr || nan_hit !== eh) begin
            failures++;
            $display("FAIL %s: got v=%0b res=%h we=%0b flag=%0b trap=%0b hit=%0b exp v=%0b res=%h we=%0b flag=%0b trap=%0b hit=%0b",
                     req, out_valid, result, wr_en, snan_flag, trap_req, nan_hit,
                     ev, er, ewe, efl, etr, eh);
        end
    endtask

    task automatic run_model(input string req, input logic [1:0] f, input logic [1:0] dk,
                             input logic [1:0] sk, input logic inv, input logic en);
        logic [79:0] d, s, er;
        logic dn, sn, sig, h, tr;
        d   = mk_op(f, dk, 1'b1, SALT_D);
        s   = mk_op(f, sk, 1'b0, SALT_S);
        dn  = (dk == 2'd1) || (dk == 2'd2);
        sn  = (sk == 2'd1) || (sk == 2'd2);
        sig = (dk == 2'd2) || (sk == 2'd2);
        h   = dn || sn || inv;
        tr  = sig && en;
        er  = dn ? quiet(f, d) : sn ? quiet(f, s) : inv ? dflt(f) : 80'h0;
        drive(f, d, s, inv, en);
        check(req, er, 1'b1, h && !tr, sig, tr, h);
    endtask

    initial begin : watchdog
        wait (cycles > 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [79:0] d, s, er;
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 reset", 80'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R2 R3 R5 R6 R7 R8 R9 R11 R12
        for (int i = 0; i < NV; i++) begin
            d = mk_op(TBL[i].f, TBL[i].dk, 1'b1, SALT_D);
            s = mk_op(TBL[i].f, TBL[i].sk, 1'b0, SALT_S);
            case (TBL[i].ch)
                2'd1: er = quiet(TBL[i].f, d);
                2'd2: er = quiet(TBL[i].f, s);
                2'd3: er = dflt(TBL[i].f);
                default: er = 80'h0;
            endcase
            drive(TBL[i].f, d, s, TBL[i].inv, TBL[i].en);
            check($sformatf("R2/R3/R6/R7/R8 table %0d", i), er, 1'b1, TBL[i].we,
                  TBL[i].flg, TBL[i].trp, TBL[i].ch != 2'd0);
        end

        // exhaustive kinds x formats x enable x invalid: R1 R4 R5 R6 R7 R11
        for (int f = 0; f < 3; f++)
            for (int dk = 0; dk < 4; dk++)
                for (int sk = 0; sk < 4; sk++)
                    for (int inv = 0; inv < 2; inv++)
                        for (int en = 0; en < 2; en++)
                            run_model($sformatf("R1/R5/R6/R7 f%0d d%0d s%0d i%0d e%0d", f, dk, sk, inv, en),
                                      2'(f), 2'(dk), 2'(sk), 1'(inv), 1'(en));

        // R9: plain numbers, no invalid
        drive(2'd1, mk_op(2'd1, 2'd0, 1'b0, SALT_D), mk_op(2'd1, 2'd3, 1'b1, SALT_S), 1'b0, 1'b1);
        check("R9 no nan", 80'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);

        // R10: idle beat after activity
        drive(2'd0, mk_op(2'd0, 2'd2, 1'b0, SALT_D), 80'h0, 1'b0, 1'b1);
        in_valid = 1'b0;
        @(negedge clk);
        check("R10 idle", 80'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

        // R4: garbage above single width is cleared, sign and payload kept
        d = {48'hDEAD_BEEF_1234, 1'b1, 8'hFF, 1'b0, 22'h2A5A5A};
        drive(2'd0, d, 80'h0, 1'b0, 1'b0);
        check("R4 upper bits", {48'h0, 1'b1, 8'hFF, 1'b1, 22'h2A5A5A}, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);

        // R4: garbage above double width
        d = {16'hBEEF, 1'b0, 11'h7FF, 1'b1, 51'h1_2345_6789_ABCD};
        drive(2'd1, 80'h0, d, 1'b0, 1'b0);
        check("R4 double upper", {16'h0, d[63:0]}, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);

        // R12: extended NaN with integer bit cleared is still a NaN
        d = {1'b0, 15'h7FFF, 1'b0, 1'b0, 62'h1};
        drive(2'd2, d, mk_op(2'd2, 2'd1, 1'b1, SALT_S), 1'b0, 1'b0);
        check("R12 int bit clear", {1'b0, 15'h7FFF, 1'b0, 1'b1, 62'h1}, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);

        // R12: integer bit set, fraction zero is infinity
        d = {1'b1, 15'h7FFF, 1'b1, 63'h0};
        drive(2'd2, d, d, 1'b0, 1'b1);
        check("R12 infinity", 80'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);

        // R8: default extended NaN with format code 3
        drive(2'd3, 80'h0, 80'h0, 1'b1, 1'b1);
        check("R8 ext alt default", {16'h7FFF, 64'hFFFF_FFFF_FFFF_FFFF}, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);

        // R10: reset mid-stream clears outputs
        drive(2'd0, mk_op(2'd0, 2'd1, 1'b0, SALT_D), 80'h0, 1'b0, 1'b0);
        rst_n = 1'b0;
        #1;
        check("R10 async reset", 80'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule